// File: doc/BRIEF.md
# Bus-Master Storage DMA Channel Registers

This block holds the software-visible control state of a two-channel bus-master DMA controller for a disk interface. Software reaches it through a byte-wide I/O port: an address, a write enable, write data, and read data that follows the address in the same cycle. Each channel has a command byte, a status byte and a 32-bit pointer to its descriptor table in memory.

The command byte drives the engine's start control and transfer direction. The pointer is also driven to the engine as a dword-aligned address. The engine sends back a busy level and two one-cycle pulses, one for error and one for interrupt. The status byte combines these engine flags with two bits that software may freely read and write. Each channel's interrupt flag is also driven out as that channel's interrupt request. Channel 0 is the primary channel and uses legacy interrupt line 14. Channel 1 is the secondary channel and uses line 15.

All pins are plain control and status signals. The port has no handshake: a write completes in the cycle in which `io_we` is high, and read data is valid whenever the address is stable.

Top module: `bmdma_regfile`

## Requirements
- R1: The address space has one 8-byte window per channel. Address bit 3 selects the channel (0 = primary, 1 = secondary), and bits 2:0 give the offset inside the window.
- R2: Reads at offset 0 return the command byte, and reads at offset 2 return the status byte. Reads at offsets 1 and 3 return 0xFF.
- R3: A write to offset 0 stores bit 0 (start) and bit 3 (direction: 1 = toward memory). These bits appear on `eng_start` and `eng_dir` on the next cycle. The other command bits read as zero.
- R4: A status write loads status bits 5 and 6 with the written values.
- R5: Status bit 0 shows `eng_busy` as sampled at the previous clock edge. A status write never changes it.
- R6: Status bits 1 (error) and 2 (interrupt) are cleared when a 1 is written to them, and a written 0 leaves them unchanged. Status bits 3, 4 and 7 always read as zero.
- R7: A pulse on `eng_err_pulse` or `eng_irq_pulse` sets status bit 1 or bit 2. The bit stays set until software clears it. If a set pulse and a clearing write arrive in the same cycle, the set wins.
- R8: Offsets 4 to 7 hold the descriptor pointer in little-endian byte order. Pointer bits 1:0 always read as zero. The pointer is driven on `eng_ptr`, with channel c using bits 32c+31 down to 32c.
- R9: `irq[c]` equals status bit 2 of channel c.
- R10: After reset, every command byte, status byte and pointer is zero, and offsets 1 and 3 still read 0xFF.
- R11: Writes to offsets 1 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte address: bit 3 selects the channel, bits 2:0 give the offset |
| io_we | input | 1 | Write strobe for one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, valid in the same cycle |
| eng_busy | input | 2 | Engine busy level, one bit per channel |
| eng_err_pulse | input | 2 | Engine error pulse, one bit per channel |
| eng_irq_pulse | input | 2 | Engine interrupt pulse, one bit per channel |
| eng_start | output | 2 | Start control, one bit per channel |
| eng_dir | output | 2 | Transfer direction, one bit per channel |
| eng_ptr | output | 64 | Descriptor pointers, 32 bits per channel |
| irq | output | 2 | Interrupt requests: bit 0 is primary (line 14), bit 1 is secondary (line 15) |

## Verification
Two functions can act on a status flag in the same cycle: the engine's set pulse and software's write-one-to-clear. The bench provokes this directly by driving an interrupt or error pulse in the same cycle as a status write that has the matching bit set. The random phase also raises pulses often while status writes are frequent. The result is judged by reading status back and checking `irq`; the flag must still be set. A second case repeats the same write without the pulse, and the flag must then clear.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int WIN_BYTES = 8;
  localparam int OFF_CMD   = 0;
  localparam int OFF_STAT  = 2;
  localparam int OFF_PTR   = 4;
  localparam int PTR_BYTES = WIN_BYTES - OFF_PTR;
  localparam int CMD_START = 0;
  localparam int CMD_DIR   = 3;
  localparam int ST_ACT    = 0;
  localparam int ST_ERR    = 1;
  localparam int ST_IRQ    = 2;
  localparam int ST_CAP0   = 5;
  localparam int ST_CAP1   = 6;
  localparam logic [7:0] RD_NONE = 8'hFF;
endpackage

// File: rtl/bmdma_status.sv
module bmdma_status
  import bmdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       busy,
  input  logic       err_set,
  input  logic       irq_set,
  output logic [7:0] stat
);
  logic       act_q, err_q, irq_q;
  logic [1:0] cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= 2'b00;
    end else begin
      act_q <= busy;
      // a set pulse beats a same-cycle clear
      err_q <= err_set | (err_q & ~(wr & wdata[ST_ERR]));
      irq_q <= irq_set | (irq_q & ~(wr & wdata[ST_IRQ]));
      if (wr) cap_q <= wdata[ST_CAP1:ST_CAP0];
    end
  end

  always_comb begin
    stat                  = '0;
    stat[ST_ACT]          = act_q;
    stat[ST_ERR]          = err_q;
    stat[ST_IRQ]          = irq_q;
    stat[ST_CAP1:ST_CAP0] = cap_q;
  end

  assert_cap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> stat[ST_CAP1:ST_CAP0] == $past(wdata[ST_CAP1:ST_CAP0]));
  assert_act_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> stat[ST_ACT]);
  assert_act_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !stat[ST_ACT]);
  assert_w1c_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wdata[ST_IRQ] && !irq_set |=> !stat[ST_IRQ]);
  assert_w1c_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wdata[ST_ERR] && !err_set |=> !stat[ST_ERR]);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> stat[ST_IRQ]);
  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> stat[ST_ERR]);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr && !irq_set |=> $stable(stat[ST_IRQ]));
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [2:0]             off,
  input  logic [7:0]             wdata,
  input  logic                   busy,
  input  logic                   err_set,
  input  logic                   irq_set,
  output logic [7:0]             rdata,
  output logic                   eng_start,
  output logic                   eng_dir,
  output logic [8*PTR_BYTES-1:0] eng_ptr,
  output logic                   irq
);
  localparam int PIDX_W = $clog2(PTR_BYTES);

  logic       start_q, dir_q;
  logic [7:0] stat;
  logic [7:0] ptr_b [PTR_BYTES];
  logic [7:0] cmd_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (wr && off == 3'(OFF_CMD)) begin
      start_q <= wdata[CMD_START];
      dir_q   <= wdata[CMD_DIR];
    end
  end

  bmdma_status u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr && off == 3'(OFF_STAT)),
    .wdata   (wdata),
    .busy    (busy),
    .err_set (err_set),
    .irq_set (irq_set),
    .stat    (stat)
  );

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
    localparam logic [7:0] KEEP = (b == 0) ? 8'hFC : 8'hFF;
    always_ff @(posedge clk) begin
      if (!rst_n)                             ptr_b[b] <= 8'h00;
      else if (wr && off == 3'(OFF_PTR + b))  ptr_b[b] <= wdata & KEEP;
    end
    assign eng_ptr[8*b +: 8] = ptr_b[b];
  end

  always_comb begin
    cmd_byte            = '0;
    cmd_byte[CMD_START] = start_q;
    cmd_byte[CMD_DIR]   = dir_q;
  end

  always_comb begin
    rdata = RD_NONE;
    if (off == 3'(OFF_CMD))           rdata = cmd_byte;
    else if (off == 3'(OFF_STAT))     rdata = stat;
    else if (off >= 3'(OFF_PTR))      rdata = ptr_b[off[PIDX_W-1:0]];
  end

  assign eng_start = start_q;
  assign eng_dir   = dir_q;
  assign irq       = stat[ST_IRQ];

  assert_cmd_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr && off == 3'(OFF_CMD) |=> eng_start == $past(wdata[CMD_START]));
  assert_ptr_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && off == 3'(OFF_PTR + 1) |=> eng_ptr[15:8] == $past(wdata));
  assert_hole_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr && off[0] && !off[2] |=> $stable(eng_start) && $stable(eng_dir));
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = $clog2(NCH) + $clog2(WIN_BYTES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          io_addr,
  input  logic                       io_we,
  input  logic [7:0]                 io_wdata,
  output logic [7:0]                 io_rdata,
  input  logic [NCH-1:0]             eng_busy,
  input  logic [NCH-1:0]             eng_err_pulse,
  input  logic [NCH-1:0]             eng_irq_pulse,
  output logic [NCH-1:0]             eng_start,
  output logic [NCH-1:0]             eng_dir,
  output logic [NCH*8*PTR_BYTES-1:0] eng_ptr,
  output logic [NCH-1:0]             irq
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int CH_W  = ADDR_W - OFF_W;
  localparam int PW    = 8 * PTR_BYTES;

  logic [CH_W-1:0] ch_sel;
  logic [2:0]      off;
  logic [7:0]      ch_rdata [NCH];

  assign ch_sel = io_addr[ADDR_W-1:OFF_W];
  assign off    = io_addr[OFF_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bmdma_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (io_we && ch_sel == CH_W'(c)),
      .off       (off),
      .wdata     (io_wdata),
      .busy      (eng_busy[c]),
      .err_set   (eng_err_pulse[c]),
      .irq_set   (eng_irq_pulse[c]),
      .rdata     (ch_rdata[c]),
      .eng_start (eng_start[c]),
      .eng_dir   (eng_dir[c]),
      .eng_ptr   (eng_ptr[PW*c +: PW]),
      .irq       (irq[c])
    );
  end

  assign io_rdata = ch_rdata[ch_sel];

  assert_hole_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    off[0] && !off[2] |-> io_rdata == RD_NONE);
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && ch_sel == '0 && off == 3'(OFF_STAT) && io_wdata[ST_IRQ] && !eng_irq_pulse[0])
      |=> !irq[0]);
endmodule

// File: tb/tb_bmdma_regfile.sv
`timescale 1ns/1ps
module tb_bmdma_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic        io_we = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [1:0]  eng_busy = '0, eng_err_pulse = '0, eng_irq_pulse = '0;
  logic [1:0]  eng_start, eng_dir, irq;
  logic [63:0] eng_ptr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_cmd [2];
  logic [1:0]  m_cap [2];
  logic        m_err [2], m_irq [2], m_act [2];
  logic [31:0] m_ptr [2];

  always #5 clk = ~clk;

  bmdma_regfile dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .eng_busy(eng_busy),
    .eng_err_pulse(eng_err_pulse), .eng_irq_pulse(eng_irq_pulse),
    .eng_start(eng_start), .eng_dir(eng_dir), .eng_ptr(eng_ptr), .irq(irq));

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    int c = a[3];
    case (a[2:0])
      3'd0: return m_cmd[c];
      3'd2: return {1'b0, m_cap[c], 2'b00, m_irq[c], m_err[c], m_act[c]};
      3'd1, 3'd3: return 8'hFF;
      default: return m_ptr[c][8*(a[1:0]) +: 8];
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = 0; m_cap[c] = 0; m_err[c] = 0; m_irq[c] = 0; m_act[c] = 0; m_ptr[c] = 0;
    end
  endtask

  // one clocked operation; returns between edges with strobes low
  task automatic step(input logic [3:0] a, input logic we, input logic [7:0] d,
                      input logic [1:0] busy, input logic [1:0] ep, input logic [1:0] ip);
    @(negedge clk);
    io_addr = a; io_we = we; io_wdata = d;
    eng_busy = busy; eng_err_pulse = ep; eng_irq_pulse = ip;
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      bit w = we && (a[3] == c);
      m_act[c] = busy[c];
      if (w && a[2:0] == 3'd0) m_cmd[c] = d & 8'h09;
      if (w && a[2:0] == 3'd2) begin
        m_cap[c] = d[6:5];
        m_err[c] = ep[c] | (m_err[c] & ~d[1]);
        m_irq[c] = ip[c] | (m_irq[c] & ~d[2]);
      end else begin
        m_err[c] = m_err[c] | ep[c];
        m_irq[c] = m_irq[c] | ip[c];
      end
      if (w && a[2]) m_ptr[c][8*a[1:0] +: 8] = (a[1:0] == 0) ? (d & 8'hFC) : d;
    end
    @(negedge clk);
    io_we = 1'b0; eng_err_pulse = '0; eng_irq_pulse = '0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a);
    io_addr = a;
    #1;
    check(req, {56'd0, io_rdata}, {56'd0, exp_read(a)});
  endtask

  task automatic ports_chk();
    for (int c = 0; c < 2; c++) begin
      check("R3 start", eng_start[c], m_cmd[c][0]);
      check("R3 dir", eng_dir[c], m_cmd[c][3]);
      check("R8 eng_ptr", eng_ptr[32*c +: 32], m_ptr[c]);
      check("R9 irq", irq[c], m_irq[c]);
    end
  endtask

  initial begin
    int unsigned w;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] busy_r;
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset values and R1/R2 window layout
    for (int a = 0; a < 16; a++) read_chk("R10 reset read", 4'(a));
    ports_chk();
    // R1 channels independent: write primary command, secondary unaffected
    step(4'h0, 1, 8'hFF, 2'b00, 0, 0);
    read_chk("R3 cmd masked", 4'h0);
    read_chk("R1 other channel", 4'h8);
    step(4'h8, 1, 8'h08, 2'b00, 0, 0);
    ports_chk();
    // R11 hole writes ignored
    step(4'h1, 1, 8'h00, 2'b00, 0, 0);
    step(4'h3, 1, 8'hFF, 2'b00, 0, 0);
    read_chk("R11 cmd kept", 4'h0);
    read_chk("R11 stat kept", 4'h2);
    read_chk("R2 hole read", 4'h3);
    // R5 bit0 follows busy, not writes
    step(4'hA, 1, 8'h00, 2'b10, 0, 0);
    read_chk("R5 act set by busy", 4'hA);
    step(4'hA, 1, 8'hFF, 2'b00, 0, 0);
    read_chk("R5 act cleared by busy only", 4'hA);
    read_chk("R4 cap bits", 4'hA);
    // R7 set pulses, R6 zero-write leaves, one-write clears
    step(4'h2, 0, 8'h00, 2'b00, 2'b01, 2'b01);
    read_chk("R7 flags set", 4'h2);
    step(4'h2, 1, 8'h60, 2'b00, 0, 0);
    read_chk("R6 zero write keeps", 4'h2);
    // R7 collision: set pulse and clear in same cycle
    step(4'h2, 1, 8'h06, 2'b00, 2'b01, 2'b01);
    read_chk("R7 set wins", 4'h2);
    ports_chk();
    step(4'h2, 1, 8'h06, 2'b00, 0, 0);
    read_chk("R6 w1c clears", 4'h2);
    ports_chk();
    // R8 pointer alignment
    step(4'hC, 1, 8'hFF, 2'b00, 0, 0);
    step(4'hF, 1, 8'hA5, 2'b00, 0, 0);
    read_chk("R8 ptr low", 4'hC);
    read_chk("R8 ptr high", 4'hF);
    ports_chk();
    // random phase
    busy_r = 0;
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] a = 4'($urandom);
      logic [1:0] ep, ip;
      if ($urandom % 8 == 0) busy_r = 2'($urandom);
      ep = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      ip = (($urandom % 5) == 0) ? 2'($urandom) : 2'b00;
      step(a, ($urandom % 10) < 7, 8'($urandom), busy_r, ep, ip);
      read_chk("R2 R6 R7 random read", 4'($urandom));
      if (i % 16 == 0) ports_chk();
    end
    // R10 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    model_reset();
    eng_busy = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int a = 0; a < 16; a++) read_chk("R10 reset again", 4'(a));
    ports_chk();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule